// File: doc/BRIEF.md
# Clock-Generator Loop Control Register

This block is the software-visible control and status register of a phase-locked-loop clock generator. It holds four fields: loop enable, automatic bandwidth mode, the bandwidth/lock bit and the pseudo-stop enable. It drives three control outputs toward the analog loop and the stop logic. The register applies protection and forcing rules that depend on three conditions: whether the loop currently clocks the bus, whether the loop supply is present, and whether the chip runs in limp-home mode.

The loop-filter bandwidth is selected in one of two ways. In manual mode, software writes the bandwidth bit directly. In automatic mode, the same bit becomes a read-only lock flag, taken from a tolerance detector through a synchronizer. In that mode, enabling the loop is all software needs to do for it to lock. The analog loop, the oscillator and the detector are outside the block and appear only as inputs.

Top module: `pll_ctrl_reg`

## Requirements
- R1: With the loop not clocking the bus and supply present, a write whose bit 0 is 1 sets the enable bit and a write whose bit 0 is 0 clears it. The new value is visible on rd_data bit 0 and pll_enable after the write edge.
- R2: While bus_on_pll is 1, a write with bit 0 equal to 0 leaves the enable bit (rd_data bit 0) unchanged.
- R3: At any edge where supply_ok is 0, the enable bit (rd_data bit 0) becomes 0, even if a write of 1 happens at that edge.
- R4: While limp_home is 1, pll_enable is 1, and rd_data bit 0 still returns the stored enable bit.
- R5: While the automatic bit (rd_data bit 1) is 1, writes do not change the bandwidth bit (rd_data bit 2). That bit then reads as the synchronized tolerance input while pll_enable is 1, and low_bandwidth equals it.
- R6: While the automatic bit is 0 before a write, that write stores its bit 2 into the bandwidth bit. rd_data bit 2 and low_bandwidth then show the stored value (1 = low bandwidth, 0 = high bandwidth).
- R7: Bit 3 is the pseudo-stop enable. It is freely writable, and pseudo_stop_en equals it.
- R8: After reset rd_data equals 8'h02 (only the automatic bit, bit 1, is set). Bits 7..4 always read 0, whatever is written to them.
- R9: In automatic mode, while pll_enable is 0, the bandwidth bit (bit 2) and low_bandwidth read 0 regardless of the tolerance input.
- R10: A change on in_tolerance reaches rd_data bit 2 after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current read value |
| bus_on_pll | input | 1 | 1 when the loop output is the bus clock |
| supply_ok | input | 1 | 1 when the loop supply is present |
| limp_home | input | 1 | 1 in limp-home mode |
| in_tolerance | input | 1 | Asynchronous detector flag: oscillator within tolerance |
| pll_enable | output | 1 | Loop enable toward the analog block |
| low_bandwidth | output | 1 | 1 = tracking (low) bandwidth, 0 = acquisition (high) |
| pseudo_stop_en | output | 1 | Keep-oscillator-running-in-stop enable |

## Verification
The bench builds the block with its default 8-bit data path, a two-stage synchronizer and fields at bits 0 to 3. With that configuration, every combination of prior enable state, bus source, supply, limp-home and written enable value can be swept. All 256 write values can then be applied twice, once per tolerance level, and each result predicted arithmetically. The small width also makes the two-edge synchronizer latency checkable edge by edge.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
   typedef enum logic {
      BW_ACQUIRE = 1'b0,
      BW_TRACK   = 1'b1
   } bw_mode_e;

   function automatic logic fields_distinct(input int a, input int b, input int c, input int d);
      return (a != b) && (a != c) && (a != d) && (b != c) && (b != d) && (c != d);
   endfunction
endpackage

// File: rtl/pll_tol_sync.sv
module pll_tol_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pll_tol_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= async_in;
            else chain[i] <= chain[(i > 0) ? i-1 : 0];
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pll_enable_bit.sv
module pll_enable_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic bus_on_pll,
   input  logic supply_ok,
   input  logic limp_home,
   output logic on_q,
   output logic pll_enable
);
   logic on_d;

   always_comb begin
      on_d = on_q;
      if (wr_en) begin
         if (wr_val) on_d = 1'b1;
         else if (!bus_on_pll) on_d = 1'b0;
      end
      if (!supply_ok) on_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_q <= 1'b0;
      else on_q <= on_d;
   end

   assign pll_enable = on_q | limp_home;
endmodule

// File: rtl/pll_bw_select.sv
module pll_bw_select
   import pll_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_auto,
   input  logic wr_acq,
   input  logic loop_enabled,
   input  logic tol_sync,
   output logic auto_q,
   output logic acq_bit
);
   logic     manual_q;
   bw_mode_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_q   <= 1'b1;
         manual_q <= 1'b0;
      end else if (wr_en) begin
         auto_q <= wr_auto;
         if (!auto_q) manual_q <= wr_acq;
      end
   end

   always_comb begin
      if (auto_q) mode = (loop_enabled && tol_sync) ? BW_TRACK : BW_ACQUIRE;
      else        mode = manual_q ? BW_TRACK : BW_ACQUIRE;
   end

   assign acq_bit = (mode == BW_TRACK);
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ON_POS      = 0,
   parameter int AUTO_POS    = 1,
   parameter int ACQ_POS     = 2,
   parameter int PSTP_POS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              bus_on_pll,
   input  logic              supply_ok,
   input  logic              limp_home,
   input  logic              in_tolerance,
   output logic              pll_enable,
   output logic              low_bandwidth,
   output logic              pseudo_stop_en
);
   import pll_ctrl_pkg::*;

   localparam int MAX_POS = (ON_POS > AUTO_POS ? ON_POS : AUTO_POS) > (ACQ_POS > PSTP_POS ? ACQ_POS : PSTP_POS)
                          ? (ON_POS > AUTO_POS ? ON_POS : AUTO_POS) : (ACQ_POS > PSTP_POS ? ACQ_POS : PSTP_POS);

   generate
      if (MAX_POS >= DATA_W) begin : g_pos_chk
         $error("pll_ctrl_reg: field position outside data width");
      end
      if (!fields_distinct(ON_POS, AUTO_POS, ACQ_POS, PSTP_POS)) begin : g_dup_chk
         $error("pll_ctrl_reg: field positions overlap");
      end
   endgenerate

   logic tol_s, on_q, auto_q, acq_bit, pstp_q;

   pll_tol_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(in_tolerance), .sync_out(tol_s)
   );

   pll_enable_bit u_en (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_data[ON_POS]),
      .bus_on_pll(bus_on_pll), .supply_ok(supply_ok), .limp_home(limp_home),
      .on_q(on_q), .pll_enable(pll_enable)
   );

   pll_bw_select u_bw (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_auto(wr_data[AUTO_POS]),
      .wr_acq(wr_data[ACQ_POS]), .loop_enabled(pll_enable), .tol_sync(tol_s),
      .auto_q(auto_q), .acq_bit(acq_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pstp_q <= 1'b0;
      else if (wr_en) pstp_q <= wr_data[PSTP_POS];
   end

   always_comb begin
      rd_data           = '0;
      rd_data[ON_POS]   = on_q;
      rd_data[AUTO_POS] = auto_q;
      rd_data[ACQ_POS]  = acq_bit;
      rd_data[PSTP_POS] = pstp_q;
   end

   assign low_bandwidth  = acq_bit;
   assign pseudo_stop_en = pstp_q;
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
module pll_ctrl_reg_chk #(
   parameter int DATA_W   = 8,
   parameter int ON_POS   = 0,
   parameter int AUTO_POS = 1,
   parameter int ACQ_POS  = 2,
   parameter int PSTP_POS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              bus_on_pll,
   input logic              supply_ok,
   input logic              limp_home,
   input logic              pll_enable,
   input logic              low_bandwidth,
   input logic              pseudo_stop_en
);
   localparam logic [DATA_W-1:0] USED = (DATA_W'(1) << ON_POS) | (DATA_W'(1) << AUTO_POS)
                                      | (DATA_W'(1) << ACQ_POS) | (DATA_W'(1) << PSTP_POS);

   AST_ENABLE_HELD_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[ON_POS] && bus_on_pll && supply_ok) |=> rd_data[ON_POS]); // R2
   AST_SUPPLY_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !rd_data[ON_POS]); // R3
   AST_LIMP_DRIVES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      limp_home |-> pll_enable); // R4
   AST_BW_OUT_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      low_bandwidth == rd_data[ACQ_POS]); // R5
   AST_PSTOP_OUT_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pseudo_stop_en == rd_data[PSTP_POS]); // R7
   AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~USED) == '0); // R8
   AST_AUTO_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[AUTO_POS] && !pll_enable) |-> !low_bandwidth); // R9
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk #(
   .DATA_W(DATA_W), .ON_POS(ON_POS), .AUTO_POS(AUTO_POS), .ACQ_POS(ACQ_POS), .PSTP_POS(PSTP_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .bus_on_pll(bus_on_pll),
   .supply_ok(supply_ok), .limp_home(limp_home), .pll_enable(pll_enable),
   .low_bandwidth(low_bandwidth), .pseudo_stop_en(pseudo_stop_en)
);

// File: tb/tb_pll_ctrl_reg.sv
module tb_pll_ctrl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       bus_on_pll = 1'b0, supply_ok = 1'b1, limp_home = 1'b0, in_tolerance = 1'b0;
   logic       pll_enable, low_bandwidth, pseudo_stop_en;
   int         total = 0, bad = 0;

   always #5 clk = ~clk;

   pll_ctrl_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .bus_on_pll(bus_on_pll), .supply_ok(supply_ok), .limp_home(limp_home),
      .in_tolerance(in_tolerance), .pll_enable(pll_enable),
      .low_bandwidth(low_bandwidth), .pseudo_stop_en(pseudo_stop_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(10 * 150000);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic       exp_on, man_acq, exp_auto, exp_acq, old_auto;
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset read", rd_data, 8'h02);
      check("R8 reset outputs", {5'b0, pll_enable, low_bandwidth, pseudo_stop_en}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 sweep: prior, bus, supply, limp, written value
      for (int k = 0; k < 32; k++) begin
         bus_on_pll = 1'b0; supply_ok = 1'b1; limp_home = 1'b0;
         do_write({7'b0, k[4]});           // set prior enable state, manual mode
         wr_en = 1'b1; wr_data = {7'b0, k[0]};
         bus_on_pll = k[3]; supply_ok = k[2]; limp_home = k[1];
         @(negedge clk);
         wr_en = 1'b0;
         if (!k[2]) exp_on = 1'b0;
         else if (k[0]) exp_on = 1'b1;
         else exp_on = k[3] ? k[4] : 1'b0;
         check("R1 R2 R3 enable bit", {7'b0, rd_data[0]}, {7'b0, exp_on});
         check("R4 pll_enable", {7'b0, pll_enable}, {7'b0, exp_on | k[1]});
      end
      bus_on_pll = 1'b0; supply_ok = 1'b1; limp_home = 1'b0;

      // R5 R6 R7 R8 R9: all write values, both tolerance levels
      do_write(8'h00);
      man_acq = 1'b0; old_auto = 1'b0;
      for (int t = 0; t < 2; t++) begin
         in_tolerance = t[0];
         repeat (3) @(negedge clk);
         for (int v = 0; v < 256; v++) begin
            d = v[7:0];
            do_write(d);
            if (!old_auto) man_acq = d[2];
            exp_auto = d[1];
            exp_acq  = exp_auto ? (d[0] & t[0]) : man_acq;
            old_auto = exp_auto;
            check("R5 R6 R7 R8 R9 read", rd_data, {4'b0, d[3], exp_acq, exp_auto, d[0]});
            check("R5 R6 low_bandwidth", {7'b0, low_bandwidth}, {7'b0, exp_acq});
            check("R7 pseudo_stop_en", {7'b0, pseudo_stop_en}, {7'b0, d[3]});
         end
      end

      // R10 synchronizer latency
      in_tolerance = 1'b0;
      do_write(8'h03);
      repeat (3) @(negedge clk);
      check("R10 settled low", {7'b0, rd_data[2]}, 8'h00);
      in_tolerance = 1'b1;
      @(negedge clk);
      check("R10 after one edge", {7'b0, rd_data[2]}, 8'h00);
      @(negedge clk);
      check("R10 after two edges", {7'b0, rd_data[2]}, 8'h01);
      // R9 off again, tolerance still high
      do_write(8'h02);
      check("R9 off reads zero", {7'b0, low_bandwidth}, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule